// File: doc/BRIEF.md
# Absmean Weight Ternarizer

This block turns one matrix of signed fixed-point weights into ternary codes that use a single shared scale. The weights arrive one per cycle. While they arrive the block adds up their magnitudes and stores each weight in an internal buffer. Once the last entry of the matrix has been taken in, the block replays the stored weights in their arrival order. For each one it emits a 2-bit code for -1, 0 or +1, which is the weight divided by the mean magnitude and rounded to the nearest of those three levels.

No divider is used. Let S be the magnitude sum and N the entry count. A weight rounds to zero when 2·N·|w| is below S, and otherwise it takes its own sign. This covers the exact half-way point, which rounds away from zero, and it also clamps large quotients to ±1. The block presents S and N beside the code stream, so a later stage can rebuild the scale S/N for dequantisation.

Top module: `absmean_ternarizer`

## Requirements
- R1: After reset, in_ready_o is 1, out_valid_o is 0, out_code_o is 00 and sum_o is 0.
- R2: While in_ready_o is 1, each cycle with in_valid_i at 1 accepts one weight. When the N-th weight is accepted, in_ready_o is 0 and out_valid_o is 1 from the next cycle onward. in_ready_o and out_valid_o are never 1 together.
- R3: While out_valid_o is 1, sum_o holds S, the sum of |w| over the N accepted weights, and it does not change. count_o always equals N.
- R4: Codes use the encoding 00 = 0, 01 = +1, 11 = -1. The value 10 never appears, and out_code_o is 00 whenever out_valid_o is 0.
- R5: An entry gets code 00 when 2·N·|w| < S. Otherwise it gets 01 for a positive w and 11 for a negative w.
- R6: An entry with 2·N·|w| exactly equal to S gets a nonzero code that follows its sign.
- R7: Quotients whose magnitude is above 1, including the most negative input value, clamp to 01 or 11.
- R8: When S is 0, every entry gets code 00 and sum_o reads 0.
- R9: The N codes come out on N consecutive cycles, in the order the weights were accepted. out_last_o is 1 only on the N-th code.
- R10: in_valid_i is ignored while in_ready_o is 0. Weights offered in that time do not enter the buffer and do not change S for any matrix.
- R11: The cycle after out_last_o, in_ready_o is 1 again and the sum restarts from 0 for the next matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A weight is offered |
| in_weight_i | input | W_WIDTH | Signed weight, two's complement |
| in_ready_o | output | 1 | Block is in its load phase and takes weights |
| out_valid_o | output | 1 | A ternary code is presented |
| out_code_o | output | 2 | Ternary code |
| out_last_o | output | 1 | Marks the final code of the matrix |
| sum_o | output | SUM_W | Magnitude sum S |
| count_o | output | CNT_W | Entry count N |

## Verification
Take the cycle whose rising edge accepts the N-th weight. out_valid_o rises in the cycle after that edge, and from then on one code is due per cycle, with no gap, for N cycles. in_ready_o returns in the cycle after the edge that carries out_last_o. The bench's reference model moves a queue forward by exactly these rules on every rising edge. It compares every output a short time after each falling edge, when the registered state has settled and the next stimulus is already driven. Each expected code is computed from the integer sum of the whole queue, so the model and the design must agree cycle by cycle, and not only in the final stream.

// File: rtl/ternary_pkg.sv
package ternary_pkg;
  typedef enum logic {PH_LOAD = 1'b0, PH_EMIT = 1'b1} phase_e;
  localparam logic [1:0] CODE_ZERO = 2'b00;
  localparam logic [1:0] CODE_POS  = 2'b01;
  localparam logic [1:0] CODE_NEG  = 2'b11;
endpackage

// File: rtl/abs_accum.sv
module abs_accum #(
  parameter int W_WIDTH = 8,
  parameter int SUM_W   = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic [W_WIDTH-1:0] w_i,
  output logic [SUM_W-1:0]   sum_o
);
  logic [W_WIDTH-1:0] mag;
  logic [SUM_W-1:0]   sum_q;

  // unsigned W-bit magnitude also covers the most negative input
  assign mag = w_i[W_WIDTH-1] ? (~w_i + 1'b1) : w_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else if (en_i)  sum_q <= sum_q + SUM_W'(mag);
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/weight_buf.sv
module weight_buf #(
  parameter int W_WIDTH = 8,
  parameter int DEPTH   = 16,
  parameter int AW      = 4
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [AW-1:0]      waddr_i,
  input  logic [W_WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]      raddr_i,
  output logic [W_WIDTH-1:0] rdata_o
);
  logic [W_WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ternary_decide.sv
module ternary_decide
  import ternary_pkg::*;
#(
  parameter int W_WIDTH   = 8,
  parameter int N_ENTRIES = 16,
  parameter int SUM_W     = 12
) (
  input  logic [W_WIDTH-1:0] w_i,
  input  logic [SUM_W-1:0]   sum_i,
  output logic [1:0]         code_o
);
  localparam int PROD_W = W_WIDTH + $clog2(2 * N_ENTRIES) + 2;

  logic [W_WIDTH-1:0] mag;
  logic [PROD_W-1:0]  prod;
  logic               to_zero;

  assign mag  = w_i[W_WIDTH-1] ? (~w_i + 1'b1) : w_i;
  // 2N|w| < S  <=>  |w|/(S/N) < 1/2
  assign prod = PROD_W'(mag) * PROD_W'(2 * N_ENTRIES);
  assign to_zero = (sum_i == '0) || (prod < PROD_W'(sum_i));

  always_comb begin
    if (to_zero)               code_o = CODE_ZERO;
    else if (w_i[W_WIDTH-1])   code_o = CODE_NEG;
    else                       code_o = CODE_POS;
  end
endmodule

// File: rtl/absmean_ternarizer.sv
module absmean_ternarizer
  import ternary_pkg::*;
#(
  parameter int W_WIDTH   = 8,
  parameter int N_ENTRIES = 16,
  parameter int SUM_W     = W_WIDTH + $clog2(N_ENTRIES),
  parameter int CNT_W     = $clog2(N_ENTRIES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [W_WIDTH-1:0] in_weight_i,
  output logic               in_ready_o,
  output logic               out_valid_o,
  output logic [1:0]         out_code_o,
  output logic               out_last_o,
  output logic [SUM_W-1:0]   sum_o,
  output logic [CNT_W-1:0]   count_o
);
  localparam int AW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(N_ENTRIES - 1);

  phase_e             phase_q;
  logic [AW-1:0]      idx_q;
  logic               accept, at_last, emitting;
  logic [W_WIDTH-1:0] rd_w;
  logic [1:0]         code;

  assign emitting = (phase_q == PH_EMIT);
  assign accept   = in_valid_i && !emitting;
  assign at_last  = (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOAD;
      idx_q   <= '0;
    end else if (accept || emitting) begin
      idx_q <= at_last ? '0 : idx_q + 1'b1;
      if (at_last) phase_q <= emitting ? PH_LOAD : PH_EMIT;
    end
  end

  abs_accum #(.W_WIDTH(W_WIDTH), .SUM_W(SUM_W)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (emitting && at_last),
    .en_i   (accept),
    .w_i    (in_weight_i),
    .sum_o  (sum_o)
  );

  weight_buf #(.W_WIDTH(W_WIDTH), .DEPTH(N_ENTRIES), .AW(AW)) u_buf (
    .clk_i   (clk_i),
    .we_i    (accept),
    .waddr_i (idx_q),
    .wdata_i (in_weight_i),
    .raddr_i (idx_q),
    .rdata_o (rd_w)
  );

  ternary_decide #(.W_WIDTH(W_WIDTH), .N_ENTRIES(N_ENTRIES), .SUM_W(SUM_W)) u_decide (
    .w_i    (rd_w),
    .sum_i  (sum_o),
    .code_o (code)
  );

  assign in_ready_o  = !emitting;
  assign out_valid_o = emitting;
  assign out_code_o  = emitting ? code : CODE_ZERO;
  assign out_last_o  = emitting && at_last;
  assign count_o     = CNT_W'(N_ENTRIES);
endmodule

// File: rtl/absmean_ternarizer_chk.sv
module absmean_ternarizer_chk #(
  parameter int SUM_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic [1:0]       out_code_o,
  input logic             out_last_o,
  input logic [SUM_W-1:0] sum_o
);
  // R2
  ready_valid_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  // R4
  code_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_code_o != 2'b10) && (out_valid_o || out_code_o == 2'b00));

  // R3
  sum_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |=> $stable(sum_o));

  // R8
  zero_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && sum_o == '0) |-> out_code_o == 2'b00);

  // R11
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |=> (in_ready_o && !out_valid_o && sum_o == '0));

  // R9
  last_in_emit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);
endmodule

bind absmean_ternarizer absmean_ternarizer_chk #(.SUM_W(SUM_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_code_o  (out_code_o),
  .out_last_o  (out_last_o),
  .sum_o       (sum_o)
);

// File: tb/tb_absmean_ternarizer.sv
`timescale 1ns/1ps
module tb_absmean_ternarizer;
  localparam int W = 8;
  localparam int N = 16;
  localparam int SUM_W = W + $clog2(N);
  localparam int CNT_W = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_weight = '0;
  logic in_ready, out_valid, out_last;
  logic [1:0] out_code;
  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] count;

  int checks = 0, failures = 0;
  bit done = 0;

  int q[$];
  int m_sum = 0;
  bit m_emit = 0;
  int m_idx = 0;

  always #5 clk = ~clk;

  absmean_ternarizer #(.W_WIDTH(W), .N_ENTRIES(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_weight_i(in_weight),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_code_o(out_code),
    .out_last_o(out_last), .sum_o(sum), .count_o(count));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int exp_code(int w, int s);
    if (s == 0 || 2 * N * iabs(w) < s) return 0;
    return (w > 0) ? 1 : 3;
  endfunction

  function automatic string code_tag(int w, int s);
    if (s == 0) return "R8";
    if (2 * N * iabs(w) == s) return "R6";
    if (2 * N * iabs(w) > 3 * s) return "R7";
    return "R5";
  endfunction

  // drive, compare against model, then advance model across the posedge
  task automatic cycle(bit v, int w);
    in_valid  = v;
    in_weight = W'(w);
    #1;
    chk(m_emit ? "R11" : "R2", int'(in_ready), int'(!m_emit));
    chk("R9", int'(out_valid), int'(m_emit));
    chk("R3", int'(count), N);
    if (m_emit) begin
      chk(code_tag(q[m_idx], m_sum), int'(out_code), exp_code(q[m_idx], m_sum));
      chk("R4", int'(out_code == 2'b10), 0);
      chk("R9", int'(out_last), int'(m_idx == N - 1));
      chk("R3", int'(sum), m_sum);
    end else begin
      chk("R4", int'(out_code), 0);
    end
    @(posedge clk);
    if (!m_emit && v) begin
      q.push_back(int'($signed(W'(w))));
      m_sum += iabs(int'($signed(W'(w))));
      if (q.size() == N) begin m_emit = 1; m_idx = 0; end
    end else if (m_emit) begin
      m_idx++;
      if (m_idx == N) begin m_emit = 0; q.delete(); m_sum = 0; end
    end
    @(negedge clk);
  endtask

  // one matrix in, full stream out; noisy drives in_valid during emission (R10)
  task automatic run_matrix(int wv[N], bit noisy);
    for (int i = 0; i < N; i++) cycle(1'b1, wv[i]);
    for (int i = 0; i < N; i++) cycle(noisy, noisy ? 127 - i : 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int wv[N];
    int s;
    repeat (2) @(negedge clk);
    #1;
    // R1
    chk("R1", int'(in_ready), 1);
    chk("R1", int'(out_valid), 0);
    chk("R1", int'(out_code), 0);
    chk("R1", int'(sum), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 mixed pattern, with gaps in in_valid
    for (int i = 0; i < N; i++) wv[i] = i * 7 - 50;
    for (int i = 0; i < N; i++) begin
      cycle(1'b1, wv[i]);
      if (i % 5 == 0) cycle(1'b0, 99);
    end
    for (int i = 0; i < N; i++) cycle(1'b0, 0);

    // R8 all zero
    for (int i = 0; i < N; i++) wv[i] = 0;
    run_matrix(wv, 1'b0);

    // R6 exact boundary: S = 160 = 2*16*5
    wv[0] = 5; wv[1] = -5; wv[2] = 7;
    for (int i = 3; i < N; i++) wv[i] = 11;
    run_matrix(wv, 1'b1);

    // R10: matrix after noisy emission; its sum must exclude the ignored weights
    for (int i = 0; i < N; i++) wv[i] = (i % 2 == 0) ? 3 : -2;
    for (int i = 0; i < N; i++) cycle(1'b1, wv[i]);
    s = 0;
    for (int i = 0; i < N; i++) s += iabs(wv[i]);
    #1 chk("R10", int'(sum), s);
    for (int i = 0; i < N; i++) cycle(1'b1, -77);

    // R7 clamp incl. most negative value
    wv[0] = -128; wv[1] = 127;
    for (int i = 2; i < N; i++) wv[i] = 1;
    run_matrix(wv, 1'b0);

    // pseudo-random matrices
    for (int m = 0; m < 6; m++) begin
      for (int i = 0; i < N; i++) wv[i] = int'($signed(W'($urandom_range(0, 255))));
      run_matrix(wv, m[0]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule